// File: doc/BRIEF.md
# Display Timing Power-Up Output Sequencer

This block sits beside the timing generator of a display panel controller and decides when the panel outputs may leave their forced-low state after a reset. It waits for the clock PLL to report lock and settle before it releases an internal run state. It then counts frame boundaries and raises output-enable once a programmable number of frames has passed. The number of frames comes from a two-bit format code, and the mapping from code to count is not monotonic.

Frame boundaries come from one of two places. In normal mode they are falling edges of an active-low vertical sync input, taken through a two-flop synchronizer. In enable-only mode they come from a vertical sync that the block builds itself: when the data-enable input stays low past two line ticks, the block drives a low pulse one line long. The block also raises a one-cycle request to load configuration at the first frame boundary. In continuous mode it raises that request again on every second boundary after the first, so a load that missed one frame is retried soon after.

Top module: `panel_out_seq`

## Requirements
- R1: The run state starts only after `pll_lock_i` has been high for SETTLE_CYC consecutive clock cycles. A low cycle of `pll_lock_i` restarts the count. Frame boundaries that arrive before the run state starts produce neither a load request nor an output-enable.
- R2: `out_en_o` stays low until the frame boundary whose number matches the format code sampled at run start: code 2'b00 selects boundary 2, 2'b01 boundary 4, 2'b10 boundary 3 and 2'b11 boundary 5. A change to `fmt_sel_i` after run start has no effect.
- R3: Once `out_en_o` is high it stays high until `rst_ni` is asserted. Asserting reset drives it low.
- R4: When `enab_only_i` is 0, a frame boundary is a falling edge of `vsync_ni` seen after two synchronizer flops. When `enab_only_i` is 1, `vsync_ni` is ignored.
- R5: When `enab_only_i` is 1, `vsync_syn_no` goes low on the clock after the third `hline_tick_i` seen while `enab_i` is low. It stays low for exactly one line, up to the next tick. Each such pulse is one frame boundary.
- R6: Only one synthesized pulse fires per low stretch of `enab_i`, however long the stretch lasts. The generator re-arms only after `enab_i` goes high.
- R7: `load_req_o` is a one-cycle high pulse at the first frame boundary after run start.
- R8: With `cont_load_i` = 1, `load_req_o` also pulses at boundaries 3, 5, 7 and so on. With `cont_load_i` = 0, it pulses only at boundary 1.
- R9: During reset and before the run state starts, `out_en_o` and `load_req_o` are low and `vsync_syn_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pll_lock_i | input | 1 | PLL lock indication |
| enab_i | input | 1 | Data-enable from the video source |
| vsync_ni | input | 1 | External vertical sync, active low, asynchronous |
| hline_tick_i | input | 1 | One-cycle pulse per horizontal line |
| fmt_sel_i | input | 2 | Format code that picks the output-enable boundary |
| enab_only_i | input | 1 | 1 = build vertical sync from data-enable |
| cont_load_i | input | 1 | 1 = repeat the load request every second frame |
| out_en_o | output | 1 | Panel output enable (outputs forced low while 0) |
| load_req_o | output | 1 | One-cycle configuration load request |
| vsync_syn_no | output | 1 | Synthesized vertical sync, active low |

## Verification
A wrong frame count or a wrong parity bit shows up as `out_en_o` rising one boundary early or late, or as `load_req_o` pulsing on an even boundary. Either fault is visible at the first affected boundary, within a few cycles of the synchronized edge. A fault in the sync generator shows up at once on `vsync_syn_no` as a pulse of the wrong length or a second pulse within one low stretch. A wrong settle counter lets a boundary that arrives before the run state starts produce a load request. The bench sweeps every format code in both source modes and both load modes, with six boundaries per run.

// File: rtl/pos_pkg.sv
package pos_pkg;
  localparam int unsigned EV_W = 3;

  typedef enum logic [1:0] {
    FMT_V2 = 2'b00,
    FMT_V4 = 2'b01,
    FMT_V3 = 2'b10,
    FMT_V5 = 2'b11
  } fmt_e;

  function automatic logic [EV_W-1:0] fmt_target(input fmt_e f);
    case (f)
      FMT_V2:  fmt_target = EV_W'(2);
      FMT_V4:  fmt_target = EV_W'(4);
      FMT_V3:  fmt_target = EV_W'(3);
      default: fmt_target = EV_W'(5);
    endcase
  endfunction
endpackage

// File: rtl/pos_rst_gate.sv
module pos_rst_gate #(
  parameter int unsigned SETTLE_CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  output logic run_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!run_q) begin
      if (!lock_i)                             cnt_q <= '0;
      else if (cnt_q == CW'(SETTLE_CYC - 1))   run_q <= 1'b1;
      else                                     cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_o = run_q;

  AST_RUN_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(lock_i)); // R1
  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q); // R1
endmodule

// File: rtl/pos_sync2.sv
module pos_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {2{RST_VAL}};
    else         ff_q <= {ff_q[0], d_i};
  end

  assign q_o = ff_q[1];
endmodule

// File: rtl/pos_vsync_gen.sv
module pos_vsync_gen #(
  parameter int unsigned LOW_LINES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic enab_i,
  input  logic tick_i,
  output logic act_o,
  output logic fire_o
);
  localparam int unsigned LW = $clog2(LOW_LINES + 1);

  logic [LW-1:0] lo_cnt_q;
  logic          armed_q, act_q, fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt_q <= '0;
      armed_q  <= 1'b1;
      act_q    <= 1'b0;
      fire_q   <= 1'b0;
    end else if (!run_i) begin
      lo_cnt_q <= '0;
      armed_q  <= 1'b1;
      act_q    <= 1'b0;
      fire_q   <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (enab_i) begin
        lo_cnt_q <= '0;
        armed_q  <= 1'b1;
      end else if (tick_i && lo_cnt_q != LW'(LOW_LINES)) begin
        lo_cnt_q <= lo_cnt_q + 1'b1;
      end
      if (act_q && tick_i) act_q <= 1'b0;
      // tick beyond LOW_LINES low lines: fire once per low stretch
      if (!enab_i && tick_i && armed_q && lo_cnt_q == LW'(LOW_LINES)) begin
        act_q   <= 1'b1;
        fire_q  <= 1'b1;
        armed_q <= 1'b0;
      end
    end
  end

  assign act_o  = act_q;
  assign fire_o = fire_q;

  AST_SYN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && act_q && !tick_i |=> act_q); // R5
  AST_SYN_FIRE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> $past(!enab_i && tick_i)); // R5
  AST_SYN_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q && !enab_i |=> !fire_q); // R6
endmodule

// File: rtl/pos_frame_seq.sv
module pos_frame_seq
  import pos_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       ev_i,
  input  logic [1:0] fmt_i,
  input  logic       cont_i,
  output logic       out_en_o,
  output logic       load_o
);
  fmt_e            fmt_q;
  logic [EV_W-1:0] ev_cnt_q, tgt;
  logic            out_en_q, load_q, par_q, first_q;

  assign tgt = fmt_target(fmt_q);

  // format tracks the pins until run starts, then freezes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fmt_q <= FMT_V2;
    else if (!run_i) fmt_q <= fmt_e'(fmt_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_cnt_q <= '0;
      out_en_q <= 1'b0;
      load_q   <= 1'b0;
      par_q    <= 1'b0;
      first_q  <= 1'b0;
    end else if (!run_i) begin
      ev_cnt_q <= '0;
      out_en_q <= 1'b0;
      load_q   <= 1'b0;
      par_q    <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (ev_i) begin
        if (ev_cnt_q != '1) ev_cnt_q <= ev_cnt_q + 1'b1;
        if (ev_cnt_q + EV_W'(1) == tgt) out_en_q <= 1'b1;
        par_q   <= ~par_q;
        first_q <= 1'b1;
        if (!par_q && (!first_q || cont_i)) load_q <= 1'b1;
      end
    end
  end

  assign out_en_o = out_en_q;
  assign load_o   = load_q;

  AST_OE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && out_en_q |=> out_en_q); // R3
  AST_OE_ON_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_en_q) |-> $past(ev_i && run_i)); // R2
  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |=> !load_q || $past(ev_i)); // R7
  AST_LOAD_ON_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> $past(ev_i && run_i)); // R8
  AST_IDLE_BEFORE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !out_en_q && !load_q); // R9
endmodule

// File: rtl/panel_out_seq.sv
module panel_out_seq #(
  parameter int unsigned SETTLE_CYC = 1024,
  parameter int unsigned LOW_LINES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pll_lock_i,
  input  logic       enab_i,
  input  logic       vsync_ni,
  input  logic       hline_tick_i,
  input  logic [1:0] fmt_sel_i,
  input  logic       enab_only_i,
  input  logic       cont_load_i,
  output logic       out_en_o,
  output logic       load_req_o,
  output logic       vsync_syn_no
);
  logic run, vs_s, vs_d_q, ext_fall, syn_act, syn_fire, ev;

  pos_rst_gate #(.SETTLE_CYC(SETTLE_CYC)) u_rst_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lock_i(pll_lock_i),
    .run_o (run)
  );

  pos_sync2 #(.RST_VAL(1'b1)) u_vs_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (vsync_ni),
    .q_o   (vs_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vs_d_q <= 1'b1;
    else         vs_d_q <= vs_s;
  end

  assign ext_fall = vs_d_q & ~vs_s;

  pos_vsync_gen #(.LOW_LINES(LOW_LINES)) u_vs_gen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .enab_i(enab_i),
    .tick_i(hline_tick_i),
    .act_o (syn_act),
    .fire_o(syn_fire)
  );

  assign ev = enab_only_i ? syn_fire : ext_fall;

  pos_frame_seq u_frame_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .ev_i    (ev),
    .fmt_i   (fmt_sel_i),
    .cont_i  (cont_load_i),
    .out_en_o(out_en_o),
    .load_o  (load_req_o)
  );

  assign vsync_syn_no = ~syn_act;

  AST_SYN_IDLE_BEFORE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> vsync_syn_no); // R9
  AST_EXT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enab_only_i && !syn_fire |=> !$rose(out_en_o) || !$stable(enab_only_i)); // R4
endmodule

// File: tb/tb_panel_out_seq.sv
`timescale 1ns/1ps
module tb_panel_out_seq;
  localparam int unsigned SETTLE = 16;
  localparam int unsigned LINE   = 8;

  logic clk = 1'b0;
  logic rst_n, lock, enab, vsync_n, tick, enab_only, cont;
  logic [1:0] fmt;
  logic out_en, load_req, syn_n;

  int n_chk = 0, n_fail = 0;
  int load_cnt = 0, syn_cnt = 0, low_len = 0, last_low = 0;
  int tick_ph = 0;
  logic syn_prev = 1'b1;

  always #2 clk = ~clk;

  panel_out_seq #(.SETTLE_CYC(SETTLE), .LOW_LINES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pll_lock_i(lock), .enab_i(enab),
    .vsync_ni(vsync_n), .hline_tick_i(tick), .fmt_sel_i(fmt),
    .enab_only_i(enab_only), .cont_load_i(cont),
    .out_en_o(out_en), .load_req_o(load_req), .vsync_syn_no(syn_n)
  );

  // free-running line tick and output monitors, all on the falling edge
  always @(negedge clk) begin
    tick    <= (tick_ph == 0);
    tick_ph <= (tick_ph == LINE - 1) ? 0 : tick_ph + 1;
    if (load_req) load_cnt <= load_cnt + 1;
    if (syn_prev && !syn_n) syn_cnt <= syn_cnt + 1;
    if (!syn_n) low_len <= low_len + 1;
    else if (!syn_prev) begin last_low <= low_len; low_len <= 0; end
    syn_prev <= syn_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; lock = 1'b0; enab = 1'b1; vsync_n = 1'b1;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic ext_frame();
    vsync_n = 1'b0; cyc(6);
    vsync_n = 1'b1; cyc(6);
  endtask

  task automatic enab_stretch();
    enab = 1'b0; cyc(5 * LINE);
    enab = 1'b1; cyc(2 * LINE);
  endtask

  function automatic int tgt_of(input int f);
    case (f)
      0: return 2;
      1: return 4;
      2: return 3;
      default: return 5;
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int l0, s0;
    rst_n = 1'b0; lock = 1'b0; enab = 1'b1; vsync_n = 1'b1;
    fmt = 2'b00; enab_only = 1'b0; cont = 1'b0;
    cyc(2);
    chk("R9 out_en in reset", int'(out_en), 0);
    chk("R9 syn in reset", int'(syn_n), 1);

    // R1: a lock glitch restarts settling; an early boundary is dropped
    do_reset();
    lock = 1'b1; cyc(SETTLE - 6);
    lock = 1'b0; cyc(1);
    lock = 1'b1; cyc(SETTLE - 8);
    l0 = load_cnt;
    ext_frame();
    chk("R1 boundary before settle", load_cnt - l0, 0);
    cyc(SETTLE);
    l0 = load_cnt;
    ext_frame();
    chk("R7 first boundary load", load_cnt - l0, 1);
    chk("R1 early boundary not counted", int'(out_en), 0);
    ext_frame();
    chk("R2 out_en at boundary 2", int'(out_en), 1);

    for (int f = 0; f < 4; f++) begin
      for (int m = 0; m < 2; m++) begin
        for (int c = 0; c < 2; c++) begin
          do_reset();
          chk("R3 reset clears out_en", int'(out_en), 0);
          fmt = 2'(f); enab_only = m[0]; cont = c[0];
          lock = 1'b1;
          cyc(SETTLE + 2);
          fmt = ~2'(f);   // must not change the target
          for (int n = 1; n <= 6; n++) begin
            l0 = load_cnt; s0 = syn_cnt;
            if (m == 1) begin
              ext_frame();   // R4: ignored in enable-only mode
              enab_stretch();
              chk("R6 one pulse per low stretch", syn_cnt - s0, 1);
              chk("R5 pulse length one line", last_low, LINE);
            end else begin
              ext_frame();
              chk("R4 no synthesized pulse", syn_cnt - s0, 0);
            end
            chk("R2/R3 out_en vs boundary", int'(out_en), int'(n >= tgt_of(f)));
            chk("R7/R8 load pulses", load_cnt - l0,
                int'(n == 1 || (c == 1 && (n % 2) == 1)));
          end
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule